// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block closes out every floating-point operation by folding the exception flags that the datapath raised into the floating-point status word. When an operation finishes, the datapath strobes `op_valid` and presents the 5-bit raised-exception vector. It also says whether the operation was a compare or an arithmetic operation. The carried-over fields of the status word come in alongside: trap type, trap-enable mask and accrued flags. One clock later the block presents the new status word. It also either raises a trap request or grants the destination-register write.

The decision falls into one of three outcomes. CLEAN means nothing was raised. ACCRUE means flags were raised but none of them is enabled. TRAP means at least one raised flag is enabled. On TRAP the block reports only the most important enabled exception, marks the trap type as an IEEE exception, leaves the accrued flags alone and withholds the write. A compare has no destination register, so it never requests a write. Only the invalid flag counts for a compare.

The status word is laid out with the current flags in bits [4:0], the accrued flags in [9:5], the trap-enable mask in [14:10] and the trap type in [17:15]. Inside each 5-bit flag field the bits are: inexact at bit 0, divide-by-zero at bit 1, underflow at bit 2, overflow at bit 3 and invalid at bit 4. Trap type 0 means none and 1 means IEEE exception; other codes are carried unchanged.

Top module: `fpx_status_unit`

## Requirements
- R1: Exception priority rises with bit index: invalid (bit 4) is most important and inexact (bit 0) is least; a trap reports the highest set bit of raised-and-enabled flags.
- R2: After reset `status_out` is all zeros and `trap_req` and `wr_en` are low.
- R3: For an arithmetic operation with any raised flag also set in the enable mask, the cycle after `op_valid` shows `trap_req`=1, `wr_en`=0 and trap type 1.
- R4: On an arithmetic trap the current field holds exactly one bit (per R1), while the accrued field and the enable mask equal their inputs unchanged.
- R5: For an arithmetic operation with no raised flag enabled, the current field equals the raised vector, the accrued field becomes the old accrued OR the raised vector, and `wr_en`=1 with `trap_req`=0.
- R6: For a compare, raised bits 0 to 3 are ignored, and `wr_en` is 0 whatever the outcome.
- R7: For a compare with invalid raised and enabled, the block traps: `trap_req`=1, trap type 1, current = invalid only, accrued unchanged.
- R8: For a compare with invalid raised but not enabled, current = invalid only, invalid is ORed into accrued, and `trap_req`=0.
- R9: With nothing raised (CLEAN), the current field is cleared and the accrued flags, enable mask and trap type are carried unchanged; an arithmetic operation still gets `wr_en`=1.
- R10: Results register one cycle after `op_valid`; in any cycle without `op_valid`, `status_out` holds and `trap_req` and `wr_en` return low.
- R11: When no trap is taken, any trap-type code (for example 5) passes through unchanged; a trap overrides it with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation finished this cycle |
| op_is_cmp | input | 1 | 1 for a compare, 0 for arithmetic |
| exc_raised | input | 5 | Flags raised by the datapath |
| prev_ttype | input | 3 | Incoming trap-type field |
| prev_tmask | input | 5 | Incoming trap-enable mask |
| prev_accr | input | 5 | Incoming accrued flags |
| status_out | output | 18 | Updated status word |
| trap_req | output | 1 | Trap requested, one-cycle pulse |
| wr_en | output | 1 | Destination write granted, one-cycle pulse |

## Verification
The raised vector is paired with enable masks so that each of CLEAN, ACCRUE and TRAP is reached for both arithmetic and compare operations. Raised sets that hold one, two or all five flags tell a true highest-set-bit pick apart from a plain copy or from a lowest-bit pick. A case where the enable mask covers only flags that were not raised separates a raised-AND-enabled test from a test of the mask alone. Compares carrying low-order raised bits, and a non-zero trap type on a non-trapping operation, show that the ignored bits and the carried fields really pass through untouched.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_W   = 5;
    localparam int TTYPE_W = 3;
    localparam int EXC_INV = 4;
    localparam logic [TTYPE_W-1:0] TT_NONE = 3'd0;
    localparam logic [TTYPE_W-1:0] TT_IEEE = 3'd1;

    typedef enum logic [1:0] {
        OUT_CLEAN  = 2'd0,
        OUT_ACCRUE = 2'd1,
        OUT_TRAP   = 2'd2
    } outcome_e;
endpackage

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] hit,
    output logic [N-1:0] onehot
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == N - 1) begin : g_top
            assign onehot[i] = hit[i];
        end else begin : g_low
            assign onehot[i] = hit[i] & ~(|hit[N-1:i+1]);
        end
    end
endmodule

// File: rtl/fpx_classify.sv
module fpx_classify
    import fpx_pkg::*;
#(
    parameter int NEXC  = EXC_W,
    parameter int TT_W  = TTYPE_W,
    parameter int INV_B = EXC_INV
) (
    input  logic            is_cmp,
    input  logic [NEXC-1:0] raised,
    input  logic [NEXC-1:0] tmask,
    input  logic [NEXC-1:0] accr_in,
    input  logic [TT_W-1:0] ttype_in,
    output outcome_e        outcome,
    output logic [NEXC-1:0] nxt_curr,
    output logic [NEXC-1:0] nxt_accr,
    output logic [TT_W-1:0] nxt_ttype,
    output logic            wr_ok
);
    localparam logic [NEXC-1:0] INV_ONLY = NEXC'(1) << INV_B;
    localparam logic [TT_W-1:0] TT_EXC   = TT_W'(TT_IEEE);

    logic [NEXC-1:0] eff;
    logic [NEXC-1:0] hit;
    logic [NEXC-1:0] top_hit;

    assign eff = is_cmp ? (raised & INV_ONLY) : raised;
    assign hit = eff & tmask;

    fpx_prio_pick #(.N(NEXC)) i_pick (
        .hit    (hit),
        .onehot (top_hit)
    );

    always_comb begin
        if (|hit)      outcome = OUT_TRAP;
        else if (|eff) outcome = OUT_ACCRUE;
        else           outcome = OUT_CLEAN;
    end

    always_comb begin
        nxt_curr  = '0;
        nxt_accr  = accr_in;
        nxt_ttype = ttype_in;
        wr_ok     = 1'b0;
        unique case (outcome)
            OUT_TRAP: begin
                nxt_curr  = top_hit;
                nxt_ttype = TT_EXC;
            end
            OUT_ACCRUE: begin
                nxt_curr = eff;
                nxt_accr = accr_in | eff;
                wr_ok    = ~is_cmp;
            end
            OUT_CLEAN: begin
                wr_ok = ~is_cmp;
            end
            default: begin
                wr_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
#(
    parameter int NEXC = EXC_W,
    parameter int TT_W = TTYPE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic                   op_is_cmp,
    input  logic [NEXC-1:0]        exc_raised,
    input  logic [TT_W-1:0]        prev_ttype,
    input  logic [NEXC-1:0]        prev_tmask,
    input  logic [NEXC-1:0]        prev_accr,
    output logic [TT_W+3*NEXC-1:0] status_out,
    output logic                   trap_req,
    output logic                   wr_en
);
    localparam int SW = TT_W + 3 * NEXC;

    outcome_e        outcome;
    logic [NEXC-1:0] nxt_curr;
    logic [NEXC-1:0] nxt_accr;
    logic [TT_W-1:0] nxt_ttype;
    logic            wr_ok;

    logic [SW-1:0]   status_d, status_q;
    logic            trap_d, trap_q;
    logic            wr_d, wr_q;

    fpx_classify #(.NEXC(NEXC), .TT_W(TT_W), .INV_B(NEXC - 1)) i_cls (
        .is_cmp    (op_is_cmp),
        .raised    (exc_raised),
        .tmask     (prev_tmask),
        .accr_in   (prev_accr),
        .ttype_in  (prev_ttype),
        .outcome   (outcome),
        .nxt_curr  (nxt_curr),
        .nxt_accr  (nxt_accr),
        .nxt_ttype (nxt_ttype),
        .wr_ok     (wr_ok)
    );

    // next-value process
    always_comb begin
        status_d = status_q;
        trap_d   = 1'b0;
        wr_d     = 1'b0;
        if (op_valid) begin
            status_d = {nxt_ttype, prev_tmask, nxt_accr, nxt_curr};
            trap_d   = (outcome == OUT_TRAP);
            wr_d     = wr_ok;
        end
    end

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            trap_q   <= 1'b0;
            wr_q     <= 1'b0;
        end else begin
            status_q <= status_d;
            trap_q   <= trap_d;
            wr_q     <= wr_d;
        end
    end

    assign status_out = status_q;
    assign trap_req   = trap_q;
    assign wr_en      = wr_q;
endmodule

// File: rtl/fpx_status_unit_chk.sv
module fpx_status_unit_chk #(
    parameter int NEXC = 5,
    parameter int TT_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   op_valid,
    input logic                   op_is_cmp,
    input logic [NEXC-1:0]        exc_raised,
    input logic [TT_W-1:0]        prev_ttype,
    input logic [NEXC-1:0]        prev_tmask,
    input logic [NEXC-1:0]        prev_accr,
    input logic [TT_W+3*NEXC-1:0] status_out,
    input logic                   trap_req,
    input logic                   wr_en
);
    localparam int ACC_LO = NEXC;
    localparam int EN_LO  = 2 * NEXC;
    localparam int TT_LO  = 3 * NEXC;

    logic [NEXC-1:0] o_cur, o_acc, o_en;
    logic [TT_W-1:0] o_tt;
    assign o_cur = status_out[0 +: NEXC];
    assign o_acc = status_out[ACC_LO +: NEXC];
    assign o_en  = status_out[EN_LO +: NEXC];
    assign o_tt  = status_out[TT_LO +: TT_W];

    a_r3_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !wr_en);
    a_r3_trap_type_ieee: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> o_tt == TT_W'(1));
    a_r4_single_current: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $countones(o_cur) == 1);
    a_r4_accrued_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_is_cmp && |(exc_raised & prev_tmask))
        |=> trap_req && o_acc == $past(prev_accr) && o_en == $past(prev_tmask));
    a_r5_accrue_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_is_cmp && !(|(exc_raised & prev_tmask)))
        |=> wr_en && !trap_req && (o_acc & $past(prev_accr)) == $past(prev_accr));
    a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_cmp) |=> !wr_en);
    a_r9_clean_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && exc_raised == '0)
        |=> o_cur == '0 && o_tt == $past(prev_ttype) && !trap_req);
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(status_out) && !trap_req && !wr_en);
endmodule

bind fpx_status_unit fpx_status_unit_chk #(.NEXC(NEXC), .TT_W(TT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_is_cmp  (op_is_cmp),
    .exc_raised (exc_raised),
    .prev_ttype (prev_ttype),
    .prev_tmask (prev_tmask),
    .prev_accr  (prev_accr),
    .status_out (status_out),
    .trap_req   (trap_req),
    .wr_en      (wr_en)
);

// File: tb/test_fpx_status_unit.sv
module test_fpx_status_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_is_cmp = 1'b0;
    logic [4:0]  exc_raised = '0;
    logic [2:0]  prev_ttype = '0;
    logic [4:0]  prev_tmask = '0;
    logic [4:0]  prev_accr = '0;
    logic [17:0] status_out;
    logic        trap_req;
    logic        wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpx_status_unit i_fpx_status_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_cmp(op_is_cmp),
        .exc_raised(exc_raised), .prev_ttype(prev_ttype), .prev_tmask(prev_tmask),
        .prev_accr(prev_accr), .status_out(status_out), .trap_req(trap_req),
        .wr_en(wr_en)
    );

    function automatic logic [17:0] mk(input logic [2:0] tt, input logic [4:0] en,
                                       input logic [4:0] acc, input logic [4:0] cur);
        return {tt, en, acc, cur};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one operation at a falling edge; outputs are sampled at the next falling edge
    task automatic run_op(input logic cmp, input logic [4:0] rz, input logic [2:0] tt,
                          input logic [4:0] en, input logic [4:0] acc);
        @(negedge clk);
        op_valid = 1'b1; op_is_cmp = cmp; exc_raised = rz;
        prev_ttype = tt; prev_tmask = en; prev_accr = acc;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [17:0] st,
                              input logic trp, input logic wr);
        check({req, " status"}, 32'(status_out), 32'(st));
        check({req, " trap"},   32'(trap_req),   32'(trp));
        check({req, " write"},  32'(wr_en),      32'(wr));
    endtask

    task automatic t_reset();
        expect_out("R2 reset", 18'd0, 1'b0, 1'b0);
    endtask

    task automatic t_accrue();
        run_op(1'b0, 5'b00101, 3'd0, 5'b00000, 5'b01000);
        expect_out("R5 accrue", mk(3'd0, 5'b00000, 5'b01101, 5'b00101), 1'b0, 1'b1);
    endtask

    task automatic t_trap_pick();
        run_op(1'b0, 5'b11010, 3'd0, 5'b01010, 5'b00011);
        expect_out("R3 R4 trap OF", mk(3'd1, 5'b01010, 5'b00011, 5'b01000), 1'b1, 1'b0);
        run_op(1'b0, 5'b00001, 3'd0, 5'b00001, 5'b00000);
        expect_out("R1 lowest NX", mk(3'd1, 5'b00001, 5'b00000, 5'b00001), 1'b1, 1'b0);
        run_op(1'b0, 5'b11111, 3'd0, 5'b11111, 5'b10101);
        expect_out("R1 all NV", mk(3'd1, 5'b11111, 5'b10101, 5'b10000), 1'b1, 1'b0);
        run_op(1'b0, 5'b00110, 3'd0, 5'b00110, 5'b00000);
        expect_out("R1 DZ+UF", mk(3'd1, 5'b00110, 5'b00000, 5'b00100), 1'b1, 1'b0);
    endtask

    task automatic t_mask_not_raised();
        run_op(1'b0, 5'b00100, 3'd0, 5'b11011, 5'b00000);
        expect_out("R3 R5 masked", mk(3'd0, 5'b11011, 5'b00100, 5'b00100), 1'b0, 1'b1);
    endtask

    task automatic t_clean();
        run_op(1'b0, 5'b00000, 3'd0, 5'b00110, 5'b10101);
        expect_out("R9 clean", mk(3'd0, 5'b00110, 5'b10101, 5'b00000), 1'b0, 1'b1);
    endtask

    task automatic t_compare();
        run_op(1'b1, 5'b10000, 3'd0, 5'b10000, 5'b00010);
        expect_out("R7 cmp trap", mk(3'd1, 5'b10000, 5'b00010, 5'b10000), 1'b1, 1'b0);
        run_op(1'b1, 5'b11111, 3'd0, 5'b01111, 5'b00001);
        expect_out("R6 R8 cmp accrue", mk(3'd0, 5'b01111, 5'b10001, 5'b10000), 1'b0, 1'b0);
        run_op(1'b1, 5'b01111, 3'd0, 5'b11111, 5'b00100);
        expect_out("R6 cmp ignored", mk(3'd0, 5'b11111, 5'b00100, 5'b00000), 1'b0, 1'b0);
    endtask

    task automatic t_ttype();
        run_op(1'b0, 5'b01000, 3'd5, 5'b00000, 5'b00000);
        expect_out("R11 pass", mk(3'd5, 5'b00000, 5'b01000, 5'b01000), 1'b0, 1'b1);
        run_op(1'b0, 5'b01000, 3'd5, 5'b01000, 5'b00000);
        expect_out("R11 override", mk(3'd1, 5'b01000, 5'b00000, 5'b01000), 1'b1, 1'b0);
    endtask

    task automatic t_hold();
        logic [17:0] held;
        run_op(1'b0, 5'b00011, 3'd0, 5'b00000, 5'b00000);
        held = status_out;
        expect_out("R10 first", mk(3'd0, 5'b00000, 5'b00011, 5'b00011), 1'b0, 1'b1);
        exc_raised = 5'b11111; prev_tmask = 5'b11111; prev_accr = 5'b11111; prev_ttype = 3'd7;
        @(negedge clk);
        expect_out("R10 hold", held, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 hold again", 32'(status_out), 32'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accrue();
        t_trap_pick();
        t_mask_not_raised();
        t_clean();
        t_compare();
        t_ttype();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule